// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Word Link

This block carries data words from one clock domain to a second, unrelated clock domain. Each word is moved with a return-to-zero handshake on two control lines. A sending controller runs on the source clock. It accepts a word through a ready/valid push port, registers the word onto a parallel bus, and raises a request line. A receiving controller runs on the destination clock. It sees the request, samples the bus, and presents the word for one destination cycle with a valid strobe. It then raises an acknowledge line.

The sender lowers its request once it sees the acknowledge. The receiver lowers its acknowledge once it sees the request go low. Only after the sender sees the acknowledge low again does it offer a new slot on the push port. Neither side assumes anything about the other side's clock. Each control line enters the far domain through a chain of flip-flops, and nothing else in that domain reads the line before the chain. The bus needs no synchronizer. It stays fixed for as long as the receiver can sample it, because the request that qualifies it arrives through the chain and so comes later than the bus.

Top module: `hs4_link`

## Requirements
- R1: When push_valid and push_ready are both high at a source clock edge, the word on push_data is accepted and the request is raised at that same edge.
- R2: Each accepted word appears on out_data exactly once. out_valid is high for exactly one destination clock cycle per word.
- R3: The sender keeps the bus at the accepted word, and keeps the request high, until it sees the synchronized acknowledge high. Changing push_data after acceptance therefore has no effect on the word that is delivered.
- R4: The receiver lowers its acknowledge only after it sees the synchronized request low. A request that is still high never produces a second delivery of the same word.
- R5: push_ready is low from the source cycle after acceptance until the sender has seen the acknowledge return low. This means push_ready comes back only after the word has been delivered.
- R6: Each control line passes through SYNC_STAGES (default 2) destination-side flip-flops before use. The time from the acceptance edge to the destination edge that raises out_valid is therefore at least 2 destination clock periods.
- R7: After reset, push_ready is high and out_valid is low, and both control lines are low.
- R8: A push_valid pulse while push_ready is low is ignored. It produces no delivery and it does not alter the next accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Source-domain clock |
| rst_m_n | input | 1 | Source-domain reset, active low, asynchronous assert |
| push_valid | input | 1 | Word offered on push_data |
| push_data | input | DATA_W | Word to transfer |
| push_ready | output | 1 | Sender idle and able to accept a word |
| clk_s | input | 1 | Destination-domain clock |
| rst_s_n | input | 1 | Destination-domain reset, active low, asynchronous assert |
| out_valid | output | 1 | One-cycle strobe marking a delivered word |
| out_data | output | DATA_W | Delivered word, held until the next delivery |

## Verification
The bench changes push_data the cycle after each acceptance. A sender that drove the bus straight from the port would then deliver the wrong word. It also pulses push_valid with a junk word while the link is busy. A controller that accepted outside the idle state would emit an extra word or a corrupted one. The delivered-word count is checked when push_ready returns and again a few cycles later. This catches a receiver that drops its acknowledge early and delivers a word twice, and a sender that reopens before the cycle is done. The bench also measures the time from acceptance to the strobe against two destination periods, which exposes a synchronizer chain cut short.

// File: rtl/hs4_pkg.sv
package hs4_pkg;

  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_REQ  = 2'd1,
    M_DROP = 2'd2
  } mst_state_t;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_ACK  = 1'b1
  } slv_state_t;

endpackage

// File: rtl/hs4_sync.sv
module hs4_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;

  // only the first flop of the chain sees the asynchronous input
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_async;
    end
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[i] <= 1'b0;
        end else begin
          chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/hs4_master.sv
module hs4_master
  import hs4_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  output logic              push_ready,
  input  logic              ack_async,
  output logic              req_o,
  output logic [DATA_W-1:0] data_o
);

  mst_state_t        state_q, state_d;
  logic              ack_s;
  logic              load_en;
  logic              req_q;
  logic [DATA_W-1:0] data_q;

  hs4_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (ack_async),
    .q_sync  (ack_s)
  );

  always_comb begin
    state_d = state_q;
    load_en = 1'b0;
    case (state_q)
      M_IDLE: begin
        if (push_valid) begin
          load_en = 1'b1;
          state_d = M_REQ;
        end
      end
      M_REQ: begin
        if (ack_s) state_d = M_DROP;
      end
      M_DROP: begin
        if (!ack_s) state_d = M_IDLE;
      end
      default: state_d = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= M_IDLE;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= (state_d == M_REQ);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (load_en) begin
      data_q <= push_data;
    end
  end

  assign push_ready = (state_q == M_IDLE);
  assign req_o      = req_q;
  assign data_o     = data_q;

  AST_REQ_RISE_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> $past(push_valid && push_ready)); // R1

  AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && $past(req_o)) |-> $stable(data_o)); // R3

  AST_REQ_FALL_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_o) |-> $past(ack_s)); // R3

  AST_READY_ONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    push_ready |-> (!req_o && !ack_s)); // R5

endmodule

// File: rtl/hs4_slave.sv
module hs4_slave
  import hs4_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_async,
  input  logic [DATA_W-1:0] data_i,
  output logic              ack_o,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  slv_state_t        state_q, state_d;
  logic              req_s;
  logic              cap_en;
  logic              ack_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  hs4_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (req_async),
    .q_sync  (req_s)
  );

  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (req_s) begin
          cap_en  = 1'b1;
          state_d = S_ACK;
        end
      end
      S_ACK: begin
        if (!req_s) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= (state_d == S_ACK);
      valid_q <= cap_en;
    end
  end

  // the bus has been steady since before req_s rose, so it is sampled directly
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (cap_en) begin
      data_q <= data_i;
    end
  end

  assign ack_o     = ack_q;
  assign out_valid = valid_q;
  assign out_data  = data_q;

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R2

  AST_ACK_RISE_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(req_s)); // R2

  AST_ACK_FALL_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> !$past(req_s)); // R4

  AST_NO_VALID_WHILE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack_o) && ack_o) |-> !out_valid); // R4

endmodule

// File: rtl/hs4_link.sv
module hs4_link
  import hs4_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_m,
  input  logic              rst_m_n,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  output logic              push_ready,
  input  logic              clk_s,
  input  logic              rst_s_n,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  logic              req_line;
  logic              ack_line;
  logic [DATA_W-1:0] bus;

  initial begin
    assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES below 2"); // R6
  end

  hs4_master #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_master (
    .clk        (clk_m),
    .rst_n      (rst_m_n),
    .push_valid (push_valid),
    .push_data  (push_data),
    .push_ready (push_ready),
    .ack_async  (ack_line),
    .req_o      (req_line),
    .data_o     (bus)
  );

  hs4_slave #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_slave (
    .clk       (clk_s),
    .rst_n     (rst_s_n),
    .req_async (req_line),
    .data_i    (bus),
    .ack_o     (ack_line),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: tb/tb_hs4_link.sv
`timescale 1ns/1ps
module tb_hs4_link;

  localparam int DW      = 8;
  localparam int HALF_M  = 5;   // 100 MHz source clock
  localparam int HALF_S  = 7;   // unrelated destination clock
  localparam int PER_S   = 2 * HALF_S;
  localparam int NVEC    = 8;

  // {gap cycles before push [11:8], word [7:0]}
  localparam logic [11:0] VEC [0:NVEC-1] = '{
    12'h0_A5, 12'h0_5A, 12'h3_00, 12'h0_FF,
    12'h1_3C, 12'h0_C3, 12'h7_81, 12'h0_7E
  };

  logic          clk_m, clk_s, rst_m_n, rst_s_n;
  logic          push_valid;
  logic [DW-1:0] push_data;
  logic          push_ready;
  logic          out_valid;
  logic [DW-1:0] out_data;

  int n_tests, n_fail;
  int rx_n;
  logic [DW-1:0] rx_data [0:63];
  longint        rx_t    [0:63];
  logic          prev_v;
  bit            done;

  hs4_link #(.DATA_W(DW), .SYNC_STAGES(2)) dut (
    .clk_m(clk_m), .rst_m_n(rst_m_n), .push_valid(push_valid),
    .push_data(push_data), .push_ready(push_ready),
    .clk_s(clk_s), .rst_s_n(rst_s_n),
    .out_valid(out_valid), .out_data(out_data)
  );

  initial clk_m = 1'b0;
  always #(HALF_M) clk_m = ~clk_m;
  initial begin
    clk_s = 1'b0;
    #3;
    forever #(HALF_S) clk_s = ~clk_s;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // destination-side monitor, sampled mid-cycle
  always @(negedge clk_s) begin
    if (!rst_s_n) begin
      prev_v = 1'b0;
    end else begin
      if (out_valid) begin
        check(!prev_v, "R2 strobe width", 2, 1);
        if (rx_n < 64) begin
          rx_data[rx_n] = out_data;
          rx_t[rx_n]    = longint'($time) - HALF_S;
        end
        rx_n++;
      end
      prev_v = out_valid;
    end
  end

  task automatic push_word(input logic [DW-1:0] w, input int gap);
    int  base;
    longint t_acc;
    int  guard;
    repeat (gap) @(negedge clk_m);
    guard = 0;
    while (!push_ready && guard < 500) begin
      @(negedge clk_m);
      guard++;
    end
    base       = rx_n;
    push_valid = 1'b1;
    push_data  = w;
    @(posedge clk_m);
    t_acc = longint'($time);
    @(negedge clk_m);
    push_valid = 1'b0;
    push_data  = ~w;                          // R3: port changes after acceptance
    check(push_ready == 1'b0, "R5 ready low after accept", push_ready, 0);
    // R8: junk offer while busy
    push_valid = 1'b1;
    push_data  = 8'hEE;
    @(negedge clk_m);
    push_valid = 1'b0;
    guard = 0;
    while (rx_n == base && guard < 500) begin
      @(negedge clk_m);
      guard++;
    end
    check(rx_n == base + 1, "R1 word delivered", rx_n - base, 1);
    if (rx_n > base && base < 64) begin
      check(rx_data[base] == w, "R3 delivered word", rx_data[base], w);
      check(rx_t[base] - t_acc >= 2 * PER_S, "R6 sync latency ns", rx_t[base] - t_acc, 2 * PER_S);
    end
    guard = 0;
    while (!push_ready && guard < 500) begin
      @(negedge clk_m);
      guard++;
    end
    check(push_ready == 1'b1, "R5 ready returns", push_ready, 1);
    check(rx_n == base + 1, "R4 no repeat at ready", rx_n - base, 1);
    repeat (6) @(negedge clk_m);
    check(rx_n == base + 1, "R8 busy offer ignored", rx_n - base, 1);
  endtask

  initial begin
    n_tests = 0; n_fail = 0; rx_n = 0; prev_v = 1'b0; done = 1'b0;
    push_valid = 1'b0; push_data = '0;
    rst_m_n = 1'b0; rst_s_n = 1'b0;
    repeat (4) @(negedge clk_m);
    check(push_ready == 1'b1, "R7 ready in reset", push_ready, 1);
    check(out_valid == 1'b0, "R7 valid in reset", out_valid, 0);
    @(negedge clk_s); rst_s_n = 1'b1;
    @(negedge clk_m); rst_m_n = 1'b1;
    repeat (3) @(negedge clk_m);
    check(push_ready == 1'b1, "R7 ready after reset", push_ready, 1);
    check(rx_n == 0, "R7 no strobe after reset", rx_n, 0);

    for (int i = 0; i < NVEC; i++) begin
      push_word(VEC[i][7:0], int'(VEC[i][11:8]));
    end

    // directed: back-to-back with identical words
    push_word(8'h55, 0);
    push_word(8'h55, 0);
    check(rx_n == NVEC + 2, "R2 total deliveries", rx_n, NVEC + 2);

    // directed: reset while idle returns to the idle state
    @(negedge clk_m);
    rst_m_n = 1'b0; rst_s_n = 1'b0;
    repeat (3) @(negedge clk_m);
    check(push_ready == 1'b1, "R7 ready on re-reset", push_ready, 1);
    check(out_valid == 1'b0, "R7 valid on re-reset", out_valid, 0);
    @(negedge clk_s); rst_s_n = 1'b1;
    @(negedge clk_m); rst_m_n = 1'b1;
    rx_n = 0;
    repeat (3) @(negedge clk_m);
    push_word(8'h96, 0);
    check(rx_n == 1, "R1 transfer after re-reset", rx_n, 1);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule